// File: doc/BRIEF.md
# ADC Calibration Cycle Sequencer

This block owns the operating mode of a sigma-delta converter channel and runs its automatic offset and gain calibrations. A 3-bit mode code, written over the bus, puts the channel into idle, continuous conversion, or one of four calibration cycles. The four cycles are offset or gain, each taken either from an internal reference or from the external input. While a calibration runs, the sequencer steers the converter input to the right source. It counts result strobes from the decimation filter and loads the measured coefficient into the offset or gain register. It then drops back to idle by itself.

The filter is seen only as a result strobe with a signed data word, so a calibration runs at whatever output rate the filter is set to. The number of filter periods per measurement depends on the chop setting, which is latched when the cycle starts. A gain cycle measures zero scale first and full scale second. It then divides a nominal span by the measured span in a sequential restoring divider. Bus writes to the two coefficient registers pass only while the channel is idle.

States: `ST_IDLE`, `ST_CONV`, `ST_OFS` (offset measurement), `ST_GZERO` (gain stage one), `ST_GFULL` (gain stage two), `ST_DIV` (gain division). Transitions:
- From IDLE or CONV, a mode write goes to IDLE, to CONV, to OFS or to GZERO.
- OFS goes to IDLE on the last strobe.
- GZERO goes to GFULL on the last strobe.
- GFULL goes to DIV on the last strobe.
- DIV goes to IDLE when the divider finishes.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset the block reads as follows. `mode_q` is 0, and `busy`, `conv_active`, `cal_done` and `mux_sel` are 0. `ofs_coef` is 0x0000 and `gain_coef` is 0x8000.
- R2: Mode codes are 0 idle, 1 conversion, 2 self-offset, 3 self-gain, 4 system-offset and 5 system-gain. Codes 6 and 7 act as idle. `mode_q` shows the active code one cycle after the write, and `conv_active` is 1 only in conversion.
- R3: A calibration code written during conversion stops the conversion at once. In the next cycle `conv_active` is 0 and `busy` is 1.
- R4: An offset calibration lasts 3 filter strobes with chop off, or 2 with chop on. The chop input is latched at the start of the cycle. The data of the last strobe becomes `ofs_coef`.
- R5: A gain calibration has two stages of the same strobe count. Stage one takes the zero reading and stage two takes the full reading. The result is gain = floor(0x8000 × 0x4000 / (full − zero)), with both readings signed. The result is 0xFFFF if the span is ≤ 0 or the quotient is above 0xFFFF.
- R6: `mux_sel` is 0 for the external input, 1 for internal zero and 2 for internal full scale. It is 1 during self-offset and self-gain stage one, and 2 during self-gain stage two. It is 0 in every other state.
- R7: When any calibration finishes, `mode_q` returns to 0 and `busy` falls. `cal_done` pulses for exactly one cycle, and the new coefficient is already visible in that cycle.
- R8: A coefficient write (`coef_wr_ofs`, `coef_wr_gain`) is visible in the next cycle if the block is idle. It is ignored during conversion or calibration.
- R9: Mode writes made during a calibration are ignored.
- R10: `busy` is 1 from the cycle after a calibration code is accepted until the cycle in which `cal_done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code to write |
| chop_en | input | 1 | Chop setting of the filter, latched at calibration start |
| filt_strobe | input | 1 | Filter result valid |
| filt_data | input | DW | Filter result, two's complement |
| coef_wr_ofs | input | 1 | Bus write to offset coefficient |
| coef_wr_gain | input | 1 | Bus write to gain coefficient |
| coef_wdata | input | DW | Bus write data |
| mode_q | output | 3 | Current mode code |
| busy | output | 1 | Calibration in progress |
| conv_active | output | 1 | Continuous conversion running |
| mux_sel | output | 2 | Converter input source |
| cal_done | output | 1 | One-cycle pulse when a coefficient is loaded |
| ofs_coef | output | DW | Offset coefficient |
| gain_coef | output | DW | Gain coefficient |

## Verification
A wrong state shows at the ports within one cycle. `mode_q`, `busy`, `conv_active` and `mux_sel` are decoded straight from the state register, so a mis-steered source or a stale mode is visible in the cycle after the transition. A strobe counter that is off by one shows up as a coefficient taken from the wrong strobe, or as `busy` falling one filter period early or late. A fault in the divider or in the zero-reading capture is only visible once `cal_done` fires, about 33 cycles after the last full-scale strobe, as a wrong `gain_coef`.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;

    localparam logic [2:0] MODE_IDLE  = 3'd0;
    localparam logic [2:0] MODE_CONV  = 3'd1;
    localparam logic [2:0] MODE_SOFS  = 3'd2;
    localparam logic [2:0] MODE_SGAIN = 3'd3;
    localparam logic [2:0] MODE_XOFS  = 3'd4;
    localparam logic [2:0] MODE_XGAIN = 3'd5;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_CONV,
        CMD_CAL
    } mode_cmd_t;

    typedef enum logic [1:0] {
        ROUTE_EXT  = 2'd0,
        ROUTE_ZERO = 2'd1,
        ROUTE_FULL = 2'd2
    } route_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_OFS,
        ST_GZERO,
        ST_GFULL,
        ST_DIV
    } seq_state_t;

    typedef struct packed {
        logic is_gain;
        logic is_sys;
    } cal_kind_t;

endpackage

// File: rtl/adc_cal_mode_dec.sv
`timescale 1ns/1ps
module adc_cal_mode_dec
    import adc_cal_pkg::*;
(
    input  logic [2:0] code,
    output mode_cmd_t  cmd,
    output cal_kind_t  kind
);

    always_comb begin
        cmd  = CMD_IDLE;
        kind = '0;
        unique case (code)
            MODE_IDLE:  cmd = CMD_IDLE;
            MODE_CONV:  cmd = CMD_CONV;
            MODE_SOFS:  cmd = CMD_CAL;
            MODE_SGAIN: begin
                cmd          = CMD_CAL;
                kind.is_gain = 1'b1;
            end
            MODE_XOFS: begin
                cmd         = CMD_CAL;
                kind.is_sys = 1'b1;
            end
            MODE_XGAIN: begin
                cmd          = CMD_CAL;
                kind.is_gain = 1'b1;
                kind.is_sys  = 1'b1;
            end
            default:    cmd = CMD_IDLE;  // spare codes behave as idle
        endcase
    end

endmodule

// File: rtl/adc_cal_strobe_cnt.sv
`timescale 1ns/1ps
module adc_cal_strobe_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             strobe,
    input  logic [CNT_W-1:0] target,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && strobe) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The strobe that completes the measurement window.
    assign last = en && strobe && (cnt_q == target - CNT_W'(1));

endmodule

// File: rtl/adc_cal_rdiv.sv
`timescale 1ns/1ps
module adc_cal_rdiv #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 17,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quot
);

    localparam int IT_W = $clog2(NUM_W);

    logic [NUM_W-1:0] num_q;
    logic [NUM_W-1:0] q_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [IT_W-1:0]  it_q;
    logic             run_q;
    logic             done_q;

    logic [DEN_W:0]   trial;
    logic             ge;
    logic [DEN_W-1:0] rem_d;

    // One restoring step per cycle: shift in a dividend bit, try the subtract.
    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        ge    = (trial >= {1'b0, den_q});
        rem_d = ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            it_q   <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                num_q <= num;
                den_q <= den;
                rem_q <= '0;
                q_q   <= '0;
                it_q  <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_d;
                num_q <= {num_q[NUM_W-2:0], 1'b0};
                q_q   <= {q_q[NUM_W-2:0], ge};
                it_q  <= it_q + 1'b1;
                if (it_q == IT_W'(NUM_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    // A zero divisor or a quotient wider than Q_W saturates to all ones.
    assign quot = ((den_q == '0) || (|q_q[NUM_W-1:Q_W])) ? '1 : q_q[Q_W-1:0];

endmodule

// File: rtl/adc_cal_coef_reg.sv
`timescale 1ns/1ps
module adc_cal_coef_reg #(
    parameter int          DW  = 16,
    parameter logic [DW-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_data,
    input  logic          hw_we,
    input  logic [DW-1:0] hw_data,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else if (hw_we) begin
            q <= hw_data;
        end else if (bus_en && bus_we) begin
            q <= bus_data;
        end
    end

endmodule

// File: rtl/adc_cal_seq.sv
`timescale 1ns/1ps
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int            DW         = 16,
    parameter logic [DW-1:0] NOM_SPAN   = 16'h4000,
    parameter int            CYC_CHOP   = 2,
    parameter int            CYC_NOCHOP = 3,
    parameter logic [DW-1:0] OFS_RST    = 16'h0000,
    parameter logic [DW-1:0] GAIN_RST   = 16'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_wdata,
    input  logic          chop_en,
    input  logic          filt_strobe,
    input  logic [DW-1:0] filt_data,
    input  logic          coef_wr_ofs,
    input  logic          coef_wr_gain,
    input  logic [DW-1:0] coef_wdata,
    output logic [2:0]    mode_q,
    output logic          busy,
    output logic          conv_active,
    output logic [1:0]    mux_sel,
    output logic          cal_done,
    output logic [DW-1:0] ofs_coef,
    output logic [DW-1:0] gain_coef
);

    localparam int CYC_MAX = (CYC_CHOP > CYC_NOCHOP) ? CYC_CHOP : CYC_NOCHOP;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam int NUM_W   = 2 * DW;
    localparam int DEN_W   = DW + 1;
    localparam logic [NUM_W-1:0] GAIN_NUM = NUM_W'(NOM_SPAN) << (DW - 1);

    seq_state_t state_q, state_d;
    mode_cmd_t  dec_cmd;
    cal_kind_t  dec_kind;
    route_t     route;

    logic [2:0]       cal_code_q;
    logic             sys_q;
    logic             chop_q;
    logic [DW-1:0]    zero_q;
    logic             done_q;

    logic             start_cal;
    logic             cnt_clr;
    logic             cnt_en;
    logic             cnt_last;
    logic [CNT_W-1:0] cnt_target;
    logic             zero_we;
    logic             ofs_hw_we;
    logic             gain_hw_we;
    logic             div_start;
    logic             div_done;
    logic [DW-1:0]    div_quot;
    logic signed [DW:0] span;
    logic [DEN_W-1:0] div_den;
    logic             idle_now;

    adc_cal_mode_dec u_dec (
        .code (mode_wdata),
        .cmd  (dec_cmd),
        .kind (dec_kind)
    );

    assign cnt_target = chop_q ? CNT_W'(CYC_CHOP) : CNT_W'(CYC_NOCHOP);
    assign cnt_en     = (state_q == ST_OFS) || (state_q == ST_GZERO) || (state_q == ST_GFULL);

    adc_cal_strobe_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .strobe (filt_strobe),
        .target (cnt_target),
        .last   (cnt_last)
    );

    // Measured span; a non-positive span is handed over as zero so the divider saturates.
    assign span    = $signed({filt_data[DW-1], filt_data}) - $signed({zero_q[DW-1], zero_q});
    assign div_den = span[DW] ? '0 : $unsigned(span);

    adc_cal_rdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (GAIN_NUM),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    assign idle_now = (state_q == ST_IDLE);

    adc_cal_coef_reg #(.DW(DW), .RST(OFS_RST)) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (idle_now),
        .bus_we   (coef_wr_ofs),
        .bus_data (coef_wdata),
        .hw_we    (ofs_hw_we),
        .hw_data  (filt_data),
        .q        (ofs_coef)
    );

    adc_cal_coef_reg #(.DW(DW), .RST(GAIN_RST)) u_gain (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (idle_now),
        .bus_we   (coef_wr_gain),
        .bus_data (coef_wdata),
        .hw_we    (gain_hw_we),
        .hw_data  (div_quot),
        .q        (gain_coef)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Cycle context captured along the way.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_code_q <= MODE_IDLE;
            sys_q      <= 1'b0;
            chop_q     <= 1'b0;
            zero_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= ofs_hw_we || gain_hw_we;
            if (start_cal) begin
                cal_code_q <= mode_wdata;
                sys_q      <= dec_kind.is_sys;
                chop_q     <= chop_en;
            end
            if (zero_we) begin
                zero_q <= filt_data;
            end
        end
    end

    // Next state and one-cycle controls.
    always_comb begin
        state_d    = state_q;
        start_cal  = 1'b0;
        cnt_clr    = 1'b0;
        zero_we    = 1'b0;
        ofs_hw_we  = 1'b0;
        gain_hw_we = 1'b0;
        div_start  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CONV: begin
                if (mode_wr) begin
                    unique case (dec_cmd)
                        CMD_IDLE: state_d = ST_IDLE;
                        CMD_CONV: state_d = ST_CONV;
                        CMD_CAL: begin
                            start_cal = 1'b1;
                            cnt_clr   = 1'b1;
                            state_d   = dec_kind.is_gain ? ST_GZERO : ST_OFS;
                        end
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_OFS: begin
                if (cnt_last) begin
                    ofs_hw_we = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_GZERO: begin
                if (cnt_last) begin
                    zero_we = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = ST_GFULL;
                end
            end
            ST_GFULL: begin
                if (cnt_last) begin
                    div_start = 1'b1;
                    state_d   = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    gain_hw_we = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        mode_q      = MODE_IDLE;
        busy        = 1'b0;
        conv_active = 1'b0;
        route       = ROUTE_EXT;
        unique case (state_q)
            ST_IDLE: mode_q = MODE_IDLE;
            ST_CONV: begin
                mode_q      = MODE_CONV;
                conv_active = 1'b1;
            end
            ST_OFS, ST_GZERO: begin
                mode_q = cal_code_q;
                busy   = 1'b1;
                route  = sys_q ? ROUTE_EXT : ROUTE_ZERO;
            end
            ST_GFULL: begin
                mode_q = cal_code_q;
                busy   = 1'b1;
                route  = sys_q ? ROUTE_EXT : ROUTE_FULL;
            end
            ST_DIV: begin
                mode_q = cal_code_q;
                busy   = 1'b1;
            end
            default: mode_q = MODE_IDLE;
        endcase
    end

    assign mux_sel  = route;
    assign cal_done = done_q;

endmodule

// File: rtl/adc_cal_seq_chk.sv
`timescale 1ns/1ps
module adc_cal_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_wr,
    input logic [2:0]    mode_wdata,
    input logic          coef_wr_ofs,
    input logic          coef_wr_gain,
    input logic [2:0]    mode_q,
    input logic          busy,
    input logic          conv_active,
    input logic [1:0]    mux_sel,
    input logic          cal_done,
    input logic [DW-1:0] ofs_coef,
    input logic [DW-1:0] gain_coef
);

    logic wr_cal_code;
    assign wr_cal_code = mode_wr && (mode_wdata >= 3'd2) && (mode_wdata <= 3'd5);

    assert_spare_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !busy && (mode_wdata >= 3'd6)) |=> (mode_q == 3'd0 && !conv_active));

    assert_conv_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cal_code && conv_active) |=> (!conv_active && busy));

    assert_route_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != 2'd3) && (conv_active -> mux_sel == 2'd0));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (mode_q == 3'd0 && !busy));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    assert_ofs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_wr_ofs && (busy || conv_active)) |=> ($stable(ofs_coef) || cal_done));

    assert_gain_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_wr_gain && (busy || conv_active)) |=> ($stable(gain_coef) || cal_done));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_wr) |=> ((busy && $stable(mode_q)) || cal_done));

    assert_busy_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mode_q >= 3'd2 && mode_q <= 3'd5 && !conv_active));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cal_code && !busy) |=> busy);

endmodule

bind adc_cal_seq adc_cal_seq_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .coef_wr_ofs  (coef_wr_ofs),
    .coef_wr_gain (coef_wr_gain),
    .mode_q       (mode_q),
    .busy         (busy),
    .conv_active  (conv_active),
    .mux_sel      (mux_sel),
    .cal_done     (cal_done),
    .ofs_coef     (ofs_coef),
    .gain_coef    (gain_coef)
);

// File: tb/adc_cal_seq_tb.sv
`timescale 1ns/1ps
module adc_cal_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_wr;
    logic [2:0]  mode_wdata;
    logic        chop_en;
    logic        filt_strobe;
    logic [15:0] filt_data;
    logic        coef_wr_ofs;
    logic        coef_wr_gain;
    logic [15:0] coef_wdata;
    logic [2:0]  mode_q;
    logic        busy;
    logic        conv_active;
    logic [1:0]  mux_sel;
    logic        cal_done;
    logic [15:0] ofs_coef;
    logic [15:0] gain_coef;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_gain;
        logic [15:0] val;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    adc_cal_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_wdata   (mode_wdata),
        .chop_en      (chop_en),
        .filt_strobe  (filt_strobe),
        .filt_data    (filt_data),
        .coef_wr_ofs  (coef_wr_ofs),
        .coef_wr_gain (coef_wr_gain),
        .coef_wdata   (coef_wdata),
        .mode_q       (mode_q),
        .busy         (busy),
        .conv_active  (conv_active),
        .mux_sel      (mux_sel),
        .cal_done     (cal_done),
        .ofs_coef     (ofs_coef),
        .gain_coef    (gain_coef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] gain_ref(input logic [15:0] z, input logic [15:0] f);
        int     d;
        longint q;
        d = int'($signed(f)) - int'($signed(z));
        if (d <= 0) return 16'hFFFF;
        q = (64'sd16384 * 64'sd32768) / d;
        if (q > 65535) return 16'hFFFF;
        return 16'(q);
    endfunction

    // Scoreboard monitor: each completed calibration pops one expected coefficient.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cal_done === 1'b1) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected cal_done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_gain) chk("R5 gain coefficient", gain_coef, e.val);
                else           chk("R4 offset coefficient", ofs_coef, e.val);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_mode(input logic [2:0] code);
        mode_wr    = 1'b1;
        mode_wdata = code;
        tick();
        mode_wr    = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] d);
        filt_strobe = 1'b1;
        filt_data   = d;
        tick();
        filt_strobe = 1'b0;
    endtask

    task automatic wr_coef(input bit gain_sel, input logic [15:0] d);
        coef_wr_ofs  = !gain_sel;
        coef_wr_gain = gain_sel;
        coef_wdata   = d;
        tick();
        coef_wr_ofs  = 1'b0;
        coef_wr_gain = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy === 1'b1 && n < 200) begin
            tick();
            n++;
        end
        chk(req, busy, 1'b0);
    endtask

    task automatic push_exp(input bit is_gain, input logic [15:0] v);
        exp_t e;
        e.is_gain = is_gain;
        e.val     = v;
        sb.push_back(e);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        mode_wr      = 1'b0;
        mode_wdata   = 3'd0;
        chop_en      = 1'b0;
        filt_strobe  = 1'b0;
        filt_data    = '0;
        coef_wr_ofs  = 1'b0;
        coef_wr_gain = 1'b0;
        coef_wdata   = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 mode_q", mode_q, 3'd0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 conv_active", conv_active, 1'b0);
        chk("R1 mux_sel", mux_sel, 2'd0);
        chk("R1 cal_done", cal_done, 1'b0);
        chk("R1 ofs_coef", ofs_coef, 16'h0000);
        chk("R1 gain_coef", gain_coef, 16'h8000);

        // R8 writes while idle
        wr_coef(1'b0, 16'h0123);
        chk("R8 idle offset write", ofs_coef, 16'h0123);
        wr_coef(1'b1, 16'h7000);
        chk("R8 idle gain write", gain_coef, 16'h7000);

        // R2 mode codes
        wr_mode(3'd1);
        chk("R2 conversion mode_q", mode_q, 3'd1);
        chk("R2 conversion active", conv_active, 1'b1);
        wr_coef(1'b0, 16'h5555);
        chk("R8 offset write ignored in conversion", ofs_coef, 16'h0123);
        wr_mode(3'd7);
        chk("R2 code 7 is idle", mode_q, 3'd0);
        chk("R2 code 7 stops conversion", conv_active, 1'b0);
        wr_mode(3'd1);
        wr_mode(3'd6);
        chk("R2 code 6 is idle", mode_q, 3'd0);

        // R3 abort conversion with a self-offset calibration, chop off
        wr_mode(3'd1);
        push_exp(1'b0, 16'h0042);
        wr_mode(3'd2);
        chk("R3 conversion stopped", conv_active, 1'b0);
        chk("R10 busy after start", busy, 1'b1);
        chk("R2 self-offset mode_q", mode_q, 3'd2);
        chk("R6 self-offset routes zero", mux_sel, 2'd1);
        strobe(16'h0011);
        wr_mode(3'd1);
        chk("R9 mode write ignored", mode_q, 3'd2);
        wr_coef(1'b0, 16'h7777);
        chk("R8 offset write ignored in calibration", ofs_coef, 16'h0123);
        strobe(16'h0022);
        chk("R4 still busy after two strobes, chop off", busy, 1'b1);
        strobe(16'h0042);
        chk("R7 idle after offset", mode_q, 3'd0);
        chk("R7 busy low", busy, 1'b0);
        chk("R7 cal_done raised", cal_done, 1'b1);
        tick();
        chk("R7 cal_done one cycle", cal_done, 1'b0);

        // R4 system offset with chop on, chop latched at start
        chop_en = 1'b1;
        push_exp(1'b0, 16'hFF80);
        wr_mode(3'd4);
        chop_en = 1'b0;
        chk("R6 system offset routes external", mux_sel, 2'd0);
        strobe(16'h0010);
        chk("R4 busy after one strobe, chop on", busy, 1'b1);
        strobe(16'hFF80);
        chk("R4 done after two strobes, chop on", busy, 1'b0);
        tick();

        // R5 self gain, chop on, unity span
        chop_en = 1'b1;
        push_exp(1'b1, gain_ref(16'h0100, 16'h4100));
        wr_mode(3'd3);
        chk("R6 self gain stage one routes zero", mux_sel, 2'd1);
        strobe(16'h0050);
        strobe(16'h0100);
        chk("R6 self gain stage two routes full", mux_sel, 2'd2);
        chk("R5 still busy in stage two", busy, 1'b1);
        strobe(16'h3000);
        strobe(16'h4100);
        chk("R6 division routes external", mux_sel, 2'd0);
        wait_idle("R5 unity gain completes");
        chk("R7 idle after gain", mode_q, 3'd0);
        chk("R5 unity gain value", gain_coef, 16'h8000);

        // R5 system gain, chop off, negative zero reading
        chop_en = 1'b0;
        push_exp(1'b1, gain_ref(16'hE000, 16'h3000));
        wr_mode(3'd5);
        strobe(16'h0001);
        strobe(16'h0002);
        strobe(16'hE000);
        chk("R6 system gain stage two routes external", mux_sel, 2'd0);
        chk("R5 system gain busy in stage two", busy, 1'b1);
        strobe(16'h1000);
        strobe(16'h2000);
        strobe(16'h3000);
        wait_idle("R5 system gain completes");
        chk("R5 system gain value", gain_coef, 16'h6666);

        // R5 saturation: negative span
        chop_en = 1'b1;
        push_exp(1'b1, 16'hFFFF);
        wr_mode(3'd3);
        strobe(16'h0000);
        strobe(16'h1000);
        strobe(16'h0000);
        strobe(16'h0800);
        wait_idle("R5 negative span completes");

        // R5 saturation: quotient above 16 bits
        wr_coef(1'b1, 16'h1234);
        chk("R8 gain write after calibration", gain_coef, 16'h1234);
        push_exp(1'b1, 16'hFFFF);
        wr_mode(3'd3);
        strobe(16'h0000);
        strobe(16'h0000);
        strobe(16'h0000);
        strobe(16'h1000);
        wait_idle("R5 small span completes");
        tick();

        chk("R7 every calibration signalled done", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule